// File: doc/BRIEF.md
# CPU ALU Flag Generation Unit

This block computes the arithmetic result and the four condition flags of a small 8-bit processor that also has a few 16-bit operations. Each cycle it can accept one operation: an operation code, two 16-bit operands, the flag register as it stands and a separate carry input. One clock later it presents the result, the complete next flag register and a per-flag write mask. Flags outside the mask are copied from the incoming flag register, so the surrounding datapath can always load the whole flag register.

The unit handles byte add, add with carry, subtract, subtract with borrow and compare. It also handles the 16-bit pair add, the stack-pointer-plus-signed-byte form, 16-bit increment and decrement, and the decimal adjust that follows a packed-BCD add or subtract. The half-carry comes from different bit positions depending on the 16-bit form. The increment and decrement forms leave every flag alone.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low and after its release with no operation, `res_q`, `flags_q`, `we_q` and `valid_q` are all zero.
- R2: An operation presented with `op_valid` high at a rising edge appears on the outputs after that edge, with `valid_q` high. A cycle with `op_valid` low drives `valid_q` low and holds `res_q`, `flags_q` and `we_q`.
- R3: Flag bits are Z=bit 3, N=bit 2, H=bit 1, C=bit 0 of `flags_in` and `flags_q`. Every bit whose `we_q` bit is 0 equals the corresponding `flags_in` bit of the operation.
- R4: Codes 0 (byte add) and 1 (byte add with carry, adding `cin`) give `res_q` = the low byte of the sum, zero-extended. H is the carry from bit 3 into bit 4, C is the carry out of bit 7, Z is set when the byte result is zero and N=0. `we_q`=4'b1111.
- R5: Codes 2 (byte subtract) and 3 (subtract with borrow, also subtracting `cin`) give the low byte of the difference, zero-extended. N=1, H is a borrow into bit 4, C is a borrow out of bit 7 and Z follows the byte result. `we_q`=4'b1111.
- R6: Code 4 (compare) sets the flags exactly as code 2 does, but `res_q` is the low byte of `opa`, zero-extended.
- R7: Code 5 (pair add) gives `res_q`=`opa`+`opb` modulo 65536. H is the carry from bit 11 into bit 12, C is the carry out of bit 15 and N=0. Z is not written: `we_q`=4'b0111.
- R8: Code 6 (stack pointer plus offset) gives `res_q`=`opa` plus the sign-extended `opb[7:0]`. H and C are the carries out of bits 3 and 7 of the low-byte add, Z=0 and N=0. `we_q`=4'b1111.
- R9: Codes 7 and 8 give `opa`+1 and `opa`-1 modulo 65536 with `we_q`=0.
- R10: For code 9 with incoming N=0, 0x60 is added and C set when incoming C=1 or `opa[7:0]`>0x99. 0x06 is added when incoming H=1 or the low nibble >9. Both tests use the original value.
- R11: For code 9 with incoming N=1, 0x60 is subtracted if incoming C=1 and 0x06 if incoming H=1, and C is kept. In both cases of code 9, Z follows the byte result, H=0, N is not written and `we_q`=4'b1011.
- R12: Codes 10 to 15 give `res_q`=0 and `we_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (see R4 to R12) |
| opa | input | 16 | First operand (accumulator, HL or SP) |
| opb | input | 16 | Second operand; the offset sits in the low byte for code 6 |
| flags_in | input | 4 | Current flag register {Z,N,H,C} |
| cin | input | 1 | Carry or borrow input for codes 1 and 3 |
| res_q | output | 16 | Registered result |
| flags_q | output | 4 | Registered next flag register {Z,N,H,C} |
| we_q | output | 4 | Registered per-flag write mask, same bit order |
| valid_q | output | 1 | Result and flags are from a new operation |

## Verification
The nibble carry and the top carry often occur in the same operation. Directed operands such as 0x8F+0x81 raise both at once, while 0x00FF+0x0001 on the pair add produces a bit-3 carry that must not show up as H. The decimal adjust can apply both the 0x06 and 0x60 corrections in one step, and the case 0x9A with N clear drives the byte to zero, setting both C and Z. Thousands of random operations with random incoming flags and carry exercise these overlaps further. Each registered output is compared against an integer model one cycle after issue.

// File: rtl/alu_flag_pkg.sv
// Shared operation codes and flag bit positions for the flag unit.
// Assumes a 4-bit operation code and a 4-bit flag register {Z,N,H,C}.
package alu_flag_pkg;
    typedef enum logic [3:0] {
        OP_ADD8  = 4'd0,
        OP_ADC8  = 4'd1,
        OP_SUB8  = 4'd2,
        OP_SBC8  = 4'd3,
        OP_CMP8  = 4'd4,
        OP_ADDW  = 4'd5,
        OP_SPOFS = 4'd6,
        OP_INCW  = 4'd7,
        OP_DECW  = 4'd8,
        OP_DADJ  = 4'd9
    } alu_op_e;

    localparam int FLAG_W = 4;
    localparam int FZ = 3;
    localparam int FN = 2;
    localparam int FH = 1;
    localparam int FC = 0;
endpackage

// File: rtl/alu_byte_arith.sv
// Byte add or subtract with carry/borrow input.
// Produces the result, the carry/borrow across the nibble boundary and
// the carry/borrow out of the top bit. Purely combinational.
module alu_byte_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         half,
    output logic         carry
);
    localparam int NB = W / 2;

    logic [NB:0] lo_ext;
    logic [W:0]  full_ext;

    // Nibble and full-width arithmetic; the extra top bit is carry or borrow
    always_comb begin
        if (sub) begin
            lo_ext   = {1'b0, a[NB-1:0]} - {1'b0, b[NB-1:0]} - {{NB{1'b0}}, cin};
            full_ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            lo_ext   = {1'b0, a[NB-1:0]} + {1'b0, b[NB-1:0]} + {{NB{1'b0}}, cin};
            full_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
        sum   = full_ext[W-1:0];
        half  = lo_ext[NB];
        carry = full_ext[W];
    end
endmodule

// File: rtl/alu_wide_arith.sv
// 16-bit path: pair add, stack pointer plus signed byte, increment and
// decrement. For the pair add the flags come from the high byte; for the
// offset form they come from the low-byte add. Combinational.
module alu_wide_arith #(
    parameter int WW = 16,
    parameter int BW = 8
) (
    input  logic [WW-1:0] a,
    input  logic [WW-1:0] b,
    input  logic [1:0]    mode,   // 0 pair add, 1 offset, 2 inc, 3 dec
    output logic [WW-1:0] res,
    output logic          half,
    output logic          carry
);
    localparam int NB  = BW / 2;
    localparam int HIH = WW - NB;   // width below the high-nibble boundary

    logic [WW:0]    pair_ext;
    logic [HIH:0]   pair_lo;
    logic [WW-1:0]  offs;
    logic [BW-1:0]  ofs_sum;
    logic           ofs_half;
    logic           ofs_carry;

    // Low-byte add that decides the offset-form flags
    alu_byte_arith #(.W(BW)) u_ofs_byte (
        .a     (a[BW-1:0]),
        .b     (b[BW-1:0]),
        .cin   (1'b0),
        .sub   (1'b0),
        .sum   (ofs_sum),
        .half  (ofs_half),
        .carry (ofs_carry)
    );

    // Select the 16-bit operation and its carries
    always_comb begin
        pair_ext = {1'b0, a} + {1'b0, b};
        pair_lo  = {1'b0, a[HIH-1:0]} + {1'b0, b[HIH-1:0]};
        offs     = {{(WW-BW){b[BW-1]}}, b[BW-1:0]};
        res      = '0;
        half     = 1'b0;
        carry    = 1'b0;
        unique case (mode)
            2'd0: begin
                res   = pair_ext[WW-1:0];
                half  = pair_lo[HIH];
                carry = pair_ext[WW];
            end
            2'd1: begin
                res   = {a[WW-1:BW] + offs[WW-1:BW] + {{(WW-BW-1){1'b0}}, ofs_carry}, ofs_sum};
                half  = ofs_half;
                carry = ofs_carry;
            end
            2'd2: res = a + {{(WW-1){1'b0}}, 1'b1};
            default: res = a - {{(WW-1){1'b0}}, 1'b1};
        endcase
    end
endmodule

// File: rtl/alu_bcd_adjust.sv
// Decimal adjust of a byte after a packed-BCD add or subtract. It uses
// the saved N, H and C. After an add, the corrections are decided from
// the unadjusted value. Combinational.
module alu_bcd_adjust #(
    parameter int BW = 8
) (
    input  logic [BW-1:0] a,
    input  logic          n_in,
    input  logic          h_in,
    input  logic          c_in,
    output logic [BW-1:0] res,
    output logic          c_out
);
    localparam int NB = BW / 2;
    localparam logic [NB-1:0] SIX = NB'(6);

    logic          fix_lo;
    logic          fix_hi;
    logic [BW-1:0] corr;

    // Decide the nibble corrections and apply them in the right direction
    always_comb begin
        if (n_in) begin
            fix_lo = h_in;
            fix_hi = c_in;
        end else begin
            fix_lo = h_in | (a[NB-1:0] > NB'(9));
            fix_hi = c_in | (a > BW'(8'h99));
        end
        corr  = {(fix_hi ? SIX : {NB{1'b0}}), (fix_lo ? SIX : {NB{1'b0}})};
        res   = n_in ? (a - corr) : (a + corr);
        c_out = n_in ? c_in : fix_hi;
    end
endmodule

// File: rtl/alu_flag_unit.sv
// Flag generation unit: selects the arithmetic path for the operation
// code, forms the next flag register and its write mask, and registers
// everything one cycle after issue. Synchronous active-low reset.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int BW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [WW-1:0] opa,
    input  logic [WW-1:0] opb,
    input  logic [3:0]    flags_in,
    input  logic          cin,
    output logic [WW-1:0] res_q,
    output logic [3:0]    flags_q,
    output logic [3:0]    we_q,
    output logic          valid_q
);
    localparam int HB = WW - BW;

    logic [BW-1:0] b_sum;
    logic          b_half, b_carry, b_sub, b_cin;
    logic [WW-1:0] w_res;
    logic          w_half, w_carry;
    logic [1:0]    w_mode;
    logic [BW-1:0] d_res;
    logic          d_carry;
    logic [WW-1:0] nxt_res;
    logic [3:0]    nxt_flags, nxt_we;

    // Decode the byte path controls from the operation code
    always_comb begin
        b_sub = (op_code == OP_SUB8) || (op_code == OP_SBC8) || (op_code == OP_CMP8);
        b_cin = ((op_code == OP_ADC8) || (op_code == OP_SBC8)) ? cin : 1'b0;
        unique case (op_code)
            OP_SPOFS: w_mode = 2'd1;
            OP_INCW:  w_mode = 2'd2;
            OP_DECW:  w_mode = 2'd3;
            default:  w_mode = 2'd0;
        endcase
    end

    alu_byte_arith #(.W(BW)) u_byte (
        .a     (opa[BW-1:0]),
        .b     (opb[BW-1:0]),
        .cin   (b_cin),
        .sub   (b_sub),
        .sum   (b_sum),
        .half  (b_half),
        .carry (b_carry)
    );

    alu_wide_arith #(.WW(WW), .BW(BW)) u_wide (
        .a     (opa),
        .b     (opb),
        .mode  (w_mode),
        .res   (w_res),
        .half  (w_half),
        .carry (w_carry)
    );

    alu_bcd_adjust #(.BW(BW)) u_dadj (
        .a     (opa[BW-1:0]),
        .n_in  (flags_in[FN]),
        .h_in  (flags_in[FH]),
        .c_in  (flags_in[FC]),
        .res   (d_res),
        .c_out (d_carry)
    );

    // Pick result, computed flags and write mask; unwritten flags pass through
    always_comb begin
        logic [3:0] calc;
        calc    = flags_in;
        nxt_res = '0;
        nxt_we  = 4'b0000;
        unique case (op_code)
            OP_ADD8, OP_ADC8, OP_SUB8, OP_SBC8: begin
                nxt_res = {{HB{1'b0}}, b_sum};
                calc    = {(b_sum == '0), b_sub, b_half, b_carry};
                nxt_we  = 4'b1111;
            end
            OP_CMP8: begin
                nxt_res = {{HB{1'b0}}, opa[BW-1:0]};
                calc    = {(b_sum == '0), 1'b1, b_half, b_carry};
                nxt_we  = 4'b1111;
            end
            OP_ADDW: begin
                nxt_res = w_res;
                calc    = {flags_in[FZ], 1'b0, w_half, w_carry};
                nxt_we  = 4'b0111;
            end
            OP_SPOFS: begin
                nxt_res = w_res;
                calc    = {1'b0, 1'b0, w_half, w_carry};
                nxt_we  = 4'b1111;
            end
            OP_INCW, OP_DECW: begin
                nxt_res = w_res;
            end
            OP_DADJ: begin
                nxt_res = {{HB{1'b0}}, d_res};
                calc    = {(d_res == '0), flags_in[FN], 1'b0, d_carry};
                nxt_we  = 4'b1011;
            end
            default: ;
        endcase
        nxt_flags = (calc & nxt_we) | (flags_in & ~nxt_we);
    end

    // Output registers: load on a valid operation, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            we_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= op_valid;
            if (op_valid) begin
                res_q   <= nxt_res;
                flags_q <= nxt_flags;
                we_q    <= nxt_we;
            end
        end
    end
endmodule

// File: rtl/alu_flag_unit_chk.sv
// Temporal checks on the flag unit's ports, attached through bind.
module alu_flag_unit_chk
    import alu_flag_pkg::*;
#(
    parameter int WW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic [WW-1:0] opa,
    input logic [3:0]    flags_in,
    input logic [WW-1:0] res_q,
    input logic [3:0]    flags_q,
    input logic [3:0]    we_q,
    input logic          valid_q
);
    // R2
    valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_q == $past(op_valid)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |-> ($stable(res_q) && $stable(flags_q) && $stable(we_q)));

    // R3
    masked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid)) |-> (((flags_q ^ $past(flags_in)) & ~we_q) == 4'b0000));

    // R6
    cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_code) == OP_CMP8))
        |-> (res_q == {8'h00, $past(opa[7:0])}));

    // R7
    pair_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_code) == OP_ADDW))
        |-> (!flags_q[FN] && (flags_q[FZ] == $past(flags_in[FZ]))));

    // R9
    incdec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && (($past(op_code) == OP_INCW) || ($past(op_code) == OP_DECW)))
        |-> (we_q == 4'b0000 && flags_q == $past(flags_in)));

    // R11
    dadj_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && ($past(op_code) == OP_DADJ))
        |-> (!flags_q[FH] && we_q == 4'b1011));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WW(WW)) u_alu_flag_unit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opa      (opa),
    .flags_in (flags_in),
    .res_q    (res_q),
    .flags_q  (flags_q),
    .we_q     (we_q),
    .valid_q  (valid_q)
);

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [15:0] opa = '0, opb = '0;
    logic [3:0]  flags_in = '0;
    logic        cin = 1'b0;
    logic [15:0] res_q;
    logic [3:0]  flags_q, we_q;
    logic        valid_q;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .flags_in(flags_in), .cin(cin),
        .res_q(res_q), .flags_q(flags_q), .we_q(we_q), .valid_q(valid_q)
    );

    // Integer model: returns {result, flags {Z,N,H,C}, write mask}
    function automatic logic [23:0] model(int op, int a, int b, logic [3:0] fi, logic ci);
        int r, h, c, off, v;
        logic [3:0] f, we;
        f = fi; we = 4'b0000; r = 0;
        a = a & 65535; b = b & 65535;
        case (op)
            0, 1: begin
                c = (op == 1) ? int'(ci) : 0;
                r = (a & 255) + (b & 255) + c;
                h = (((a & 15) + (b & 15) + c) > 15) ? 1 : 0;
                f = {((r & 255) == 0), 1'b0, h[0], (r > 255)};
                r = r & 255; we = 4'b1111;
            end
            2, 3, 4: begin
                c = (op == 3) ? int'(ci) : 0;
                r = (a & 255) - (b & 255) - c;
                h = (((a & 15) - (b & 15) - c) < 0) ? 1 : 0;
                f = {((r & 255) == 0), 1'b1, h[0], (r < 0)};
                r = (op == 4) ? (a & 255) : (r & 255);
                we = 4'b1111;
            end
            5: begin
                r = a + b;
                h = (((a & 4095) + (b & 4095)) > 4095) ? 1 : 0;
                f = {fi[3], 1'b0, h[0], (r > 65535)};
                r = r & 65535; we = 4'b0111;
            end
            6: begin
                off = b & 255;
                if (off > 127) off = off - 256;
                r = (a + off) & 65535;
                h = (((a & 15) + (b & 15)) > 15) ? 1 : 0;
                c = (((a & 255) + (b & 255)) > 255) ? 1 : 0;
                f = {1'b0, 1'b0, h[0], c[0]};
                we = 4'b1111;
            end
            7: r = (a + 1) & 65535;
            8: r = (a - 1) & 65535;
            9: begin
                v = a & 255; c = int'(fi[0]);
                if (!fi[2]) begin
                    if (fi[0] || v > 153) begin v = v + 96; c = 1; end
                    if (fi[1] || (((a & 255) & 15) > 9)) v = v + 6;
                end else begin
                    if (fi[0]) v = v - 96;
                    if (fi[1]) v = v - 6;
                end
                r = v & 255;
                f = {(r == 0), fi[2], 1'b0, c[0]};
                we = 4'b1011;
            end
            default: r = 0;
        endcase
        return {r[15:0], f, we};
    endfunction

    function automatic string req_of(int op);
        case (op)
            0, 1: return "R4";
            2, 3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7, 8: return "R9";
            9: return fi_n_dummy(op);
            default: return "R12";
        endcase
    endfunction

    function automatic string fi_n_dummy(int op);
        return (op == 9 && flags_in[2]) ? "R11" : "R10";
    endfunction

    // Issue one operation at a falling edge and check it one cycle later
    task automatic run_op(int op, logic [15:0] a, logic [15:0] b, logic [3:0] fi, logic ci);
        logic [23:0] exp;
        string tag;
        op_code = op[3:0]; opa = a; opb = b; flags_in = fi; cin = ci; op_valid = 1'b1;
        exp = model(op, int'(a), int'(b), fi, ci);
        tag = req_of(op);
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0;
        n_chk++;
        if (res_q !== exp[23:8] || flags_q !== exp[7:4] || we_q !== exp[3:0] || valid_q !== 1'b1) begin
            n_bad++;
            $display("FAIL %s (R3) op=%0d a=%h b=%h fi=%b cin=%b: got res=%h fl=%b we=%b v=%b exp res=%h fl=%b we=%b v=1",
                     tag, op, a, b, fi, ci, res_q, flags_q, we_q, valid_q, exp[23:8], exp[7:4], exp[3:0]);
        end
    endtask

    task automatic expect_val(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] keep_r;
        logic [3:0]  keep_f, keep_w;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        expect_val("R1 reset", {res_q, flags_q, we_q, valid_q, 7'd0}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val("R1 after release", {res_q, flags_q, we_q, valid_q, 7'd0}, 32'd0);

        // Directed corners
        run_op(0, 16'h008F, 16'h0081, 4'b0000, 1'b0);  // R4 H and C together
        run_op(0, 16'h000F, 16'h0001, 4'b0000, 1'b0);  // R4 nibble carry only
        run_op(1, 16'h00FF, 16'h0000, 4'b0000, 1'b1);  // R4 carry-in wraps to zero
        run_op(3, 16'h0010, 16'h000F, 4'b0000, 1'b1);  // R5 borrow chain to zero
        run_op(4, 16'h0042, 16'h0042, 4'b0000, 1'b0);  // R6 equal compare
        run_op(5, 16'h0FFF, 16'h0001, 4'b1000, 1'b0);  // R7 bit-11 carry, Z kept
        run_op(5, 16'h00FF, 16'h0001, 4'b0010, 1'b0);  // R7 bit-3 carry gives no H
        run_op(6, 16'hFFF8, 16'h0008, 4'b1111, 1'b0);  // R8 wraps to zero, Z=0
        run_op(6, 16'h0005, 16'h00FF, 4'b0000, 1'b0);  // R8 negative offset
        run_op(8, 16'h0000, 16'h0000, 4'b1010, 1'b0);  // R9 decrement wraps
        run_op(7, 16'hFFFF, 16'h0000, 4'b0101, 1'b0);  // R9 increment wraps
        run_op(9, 16'h009A, 16'h0000, 4'b0000, 1'b0);  // R10 both fixes, zero
        run_op(9, 16'h0045, 16'h0000, 4'b0010, 1'b0);  // R10 low fix via H
        run_op(9, 16'h0006, 16'h0000, 4'b0111, 1'b0);  // R11 subtract both fixes
        run_op(12, 16'h1234, 16'h5678, 4'b1001, 1'b0); // R12 undefined code

        // R2: idle cycle holds outputs even when inputs change
        keep_r = res_q; keep_f = flags_q; keep_w = we_q;
        op_code = 4'd0; opa = 16'h00FF; opb = 16'h00FF; flags_in = 4'b0000;
        @(posedge clk); @(negedge clk);
        expect_val("R2 idle hold", {res_q, flags_q, we_q, valid_q, 7'd0},
                   {keep_r, keep_f, keep_w, 1'b0, 7'd0});

        // Random mix over all codes, random flags and carry
        for (int i = 0; i < 3000; i++) begin
            run_op(int'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
                   4'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule